// File: doc/BRIEF.md
# Bit-Serial Integer ALU with Short Multiply

This block performs the integer arithmetic of a small bit-serial processor core. Operands arrive one bit pair per clock, least significant bit first, over an operand stream of 32 beats. The result leaves on a result stream of 32 bits during the next 32-beat slot. Logic, add and subtract, and the set-less-than compares occupy one slot each. Their results stream out while the next operation's operands stream in, so back-to-back operations sustain one operation per 32 beats. Shifts and the multiply use the slot after their operands to produce the result, so they occupy two slots. The multiply forms the low 32 bits of the full first operand times the low 16 bits of the second. The upper-immediate forms (loading an immediate, or adding one to the program counter) are ordinary ADD operations whose first operand is zero or the program counter.

The operand stream is valid/ready. A beat transfers on a clock where `in_valid` and `in_ready` are both high. The opcode is taken only on the first beat of an operation. Dropping `in_valid` in the middle of an operand slot pauses the whole unit, including the result bits that share that slot. The result stream has no ready input: the consumer must take every bit presented with `out_valid`. `out_last` marks the 32nd bit of each result.

Top module: `serial_alu`

## Requirements
- R1: Opcodes on `in_op`: 0 AND, 1 OR, 2 XOR, 3 ADD, 4 SUB, 5 SLT (signed), 6 SLTU (unsigned), 7 SLL, 8 SRL, 9 SRA, 10 MUL. The opcode is sampled on the first beat of an operation only, and its value on later beats has no effect. Operand bits arrive LSB first, with `in_a` as the first operand and `in_b` as the second.
- R2: AND, OR and XOR return the bitwise function of the two 32-bit operands.
- R3: ADD returns a+b and SUB returns a-b, both modulo 2^32, with the carry running from bit 0 upward.
- R4: SLT and SLTU return 1 in bit 0 when a<b (two's-complement or unsigned, overflow-correct), else 0; bits 1 to 31 are zero.
- R5: A one-slot operation's result streams out during the slot after its operands, overlapped with the next operation's operands. `in_ready` stays high across a run of one-slot operations.
- R6: If no operation starts at a slot boundary while a result is waiting, the result streams out on 32 consecutive clocks. `in_ready` is low for the last 31 of them.
- R7: SLL, SRL and SRA shift the first operand by the low 5 bits of the second. SRA fills with bit 31, and SRL and SLL fill with zero. The result streams in the slot after the operands, during which `in_ready` is low on every clock.
- R8: MUL returns the low 32 bits of a times b[15:0]. Bits 16 to 31 of b have no effect. It uses the same two-slot timing as R7.
- R9: While an operand slot is in progress and `in_valid` is low, the beat position holds and `out_valid` is low.
- R10: `out_last` is high exactly on the 32nd bit of each result.
- R11: During and after reset `out_valid` and `out_last` are low and `in_ready` is high.
- R12: Opcodes 11 to 15 complete in one slot with a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand beat present |
| in_ready | output | 1 | Unit accepts an operand beat |
| in_op | input | 4 | Opcode, sampled on the first beat |
| in_a | input | 1 | First operand bit |
| in_b | input | 1 | Second operand bit |
| out_valid | output | 1 | Result bit present |
| out_bit | output | 1 | Result bit, LSB first |
| out_last | output | 1 | Final bit of the result |

## Verification
The logic operations use alternating-nibble and mixed patterns, so that a swapped or wrong function changes many bit positions. The adds use operands whose carry runs through all 32 bits, and the subtract produces a borrow through all 32 bits, which exposes a dropped or wrong initial carry. The compares cover equal operands, sign-opposite operands where signed and unsigned answers differ, and the overflow corner at 0x80000000. Shifts use amounts 0, 4, 7 and 31 with junk in the upper bits of the second operand, and multiplies use all-ones upper halves in the second operand. Together these show whether the shift-amount and multiplier truncation is done. Stalls, late opcode changes, the drain slot and back-to-back runs check that the timing keeps each result aligned with its slot.

// File: rtl/serial_alu_pkg.sv
package serial_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND  = 4'd0,
    OP_OR   = 4'd1,
    OP_XOR  = 4'd2,
    OP_ADD  = 4'd3,
    OP_SUB  = 4'd4,
    OP_SLT  = 4'd5,
    OP_SLTU = 4'd6,
    OP_SLL  = 4'd7,
    OP_SRL  = 4'd8,
    OP_SRA  = 4'd9,
    OP_MUL  = 4'd10
  } alu_op_e;

  // Slot kinds: idle boundary, operand slot, result-only slot, compute-and-emit slot
  typedef enum logic [1:0] {
    SL_IDLE  = 2'd0,
    SL_RUN   = 2'd1,
    SL_DRAIN = 2'd2,
    SL_EXEC  = 2'd3
  } slot_e;

  function automatic logic op_two_slot(alu_op_e op);
    return (op == OP_SLL) || (op == OP_SRL) || (op == OP_SRA) || (op == OP_MUL);
  endfunction

  function automatic logic op_subtracts(alu_op_e op);
    return (op == OP_SUB) || (op == OP_SLT) || (op == OP_SLTU);
  endfunction

  function automatic logic op_compares(alu_op_e op);
    return (op == OP_SLT) || (op == OP_SLTU);
  endfunction

endpackage

// File: rtl/serial_alu_addsub.sv
module serial_alu_addsub (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic first,
  input  logic sub,
  input  logic a_bit,
  input  logic b_bit,
  output logic sum_bit,
  output logic lt_signed,
  output logic lt_unsigned
);

  logic carry_q;
  logic bx;
  logic cin;
  logic cout;

  assign bx      = b_bit ^ sub;
  assign cin     = first ? sub : carry_q;
  assign sum_bit = a_bit ^ bx ^ cin;
  assign cout    = (a_bit & bx) | (a_bit & cin) | (bx & cin);

  // Valid on the MSB beat: sign of the difference corrected by overflow, or borrow out
  assign lt_signed   = a_bit ^ bx ^ cout;
  assign lt_unsigned = ~cout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  carry_q <= 1'b0;
    else if (en) carry_q <= cout;
  end

endmodule

// File: rtl/serial_alu_shsel.sv
module serial_alu_shsel #(
  parameter  int XLEN = 32,
  localparam int SH_W = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] opnd,
  input  logic [SH_W-1:0] shamt,
  input  logic [SH_W-1:0] idx,
  input  logic            left,
  input  logic            arith,
  output logic            bit_o
);

  logic [SH_W:0] up;

  assign up = {1'b0, idx} + {1'b0, shamt};

  always_comb begin
    if (left) begin
      bit_o = (idx >= shamt) ? opnd[idx - shamt] : 1'b0;
    end else begin
      bit_o = up[SH_W] ? (arith & opnd[XLEN-1]) : opnd[up[SH_W-1:0]];
    end
  end

endmodule

// File: rtl/serial_alu_mulcol.sv
module serial_alu_mulcol #(
  parameter  int MUL_W = 16,
  localparam int PC_W  = $clog2(MUL_W + 1),
  localparam int ACC_W = $clog2(2 * MUL_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             a_bit,
  input  logic [MUL_W-1:0] b_lo,
  output logic             p_bit
);

  logic [MUL_W-1:0] win_q;
  logic [MUL_W-1:0] win_d;
  logic [MUL_W-1:0] prod;
  logic [PC_W-1:0]  col;
  logic [ACC_W-1:0] sum;
  logic [ACC_W-2:0] acc_q;

  // win_d[j] holds the first-operand bit from j beats ago
  assign win_d = {win_q[MUL_W-2:0], a_bit};

  for (genvar j = 0; j < MUL_W; j++) begin : g_pp
    assign prod[j] = win_d[j] & b_lo[j];
  end

  always_comb begin
    col = '0;
    for (int j = 0; j < MUL_W; j++) col = col + PC_W'(prod[j]);
  end

  assign sum   = ACC_W'(col) + ACC_W'(acc_q);
  assign p_bit = sum[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      acc_q <= '0;
    end else if (clr) begin
      win_q <= '0;
      acc_q <= '0;
    end else if (en) begin
      win_q <= win_d;
      acc_q <= sum[ACC_W-1:1];
    end
  end

endmodule

// File: rtl/serial_alu.sv
module serial_alu
  import serial_alu_pkg::*;
#(
  parameter  int XLEN  = 32,
  parameter  int MUL_W = 16,
  localparam int CNT_W = $clog2(XLEN),
  localparam int MB_W  = $clog2(MUL_W)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [3:0] in_op,
  input  logic       in_a,
  input  logic       in_b,
  output logic       out_valid,
  output logic       out_bit,
  output logic       out_last
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(XLEN - 1);

  slot_e            mode_q, mode_d;
  logic [CNT_W-1:0] cnt_q;
  alu_op_e          op_q;
  alu_op_e          cur_op;
  logic             pend_q;
  logic [XLEN-1:0]  res_q;
  logic [XLEN-1:0]  opa_q;
  logic [MUL_W-1:0] opb_q;

  logic step, accept, at_idle, at_end, first;
  logic sum_bit, lt_s, lt_u, cmp_bit, res_bit;
  logic sh_bit, mul_bit, exec_bit;

  assign at_idle = (mode_q == SL_IDLE);
  assign cur_op  = at_idle ? alu_op_e'(in_op) : op_q;
  assign first   = (cnt_q == '0);

  always_comb begin
    in_ready  = 1'b0;
    step      = 1'b0;
    out_valid = 1'b0;
    mode_d    = mode_q;
    unique case (mode_q)
      SL_IDLE: begin
        in_ready  = 1'b1;
        step      = in_valid | pend_q;
        out_valid = pend_q;
        if (in_valid)    mode_d = SL_RUN;
        else if (pend_q) mode_d = SL_DRAIN;
      end
      SL_RUN: begin
        in_ready  = 1'b1;
        step      = in_valid;
        out_valid = pend_q & in_valid;
        if (in_valid && cnt_q == LAST) mode_d = op_two_slot(op_q) ? SL_EXEC : SL_IDLE;
      end
      default: begin
        step      = 1'b1;
        out_valid = 1'b1;
        if (cnt_q == LAST) mode_d = SL_IDLE;
      end
    endcase
  end

  assign accept = in_valid & in_ready;
  assign at_end = step & (cnt_q == LAST);

  serial_alu_addsub u_add (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (accept),
    .first       (first),
    .sub         (op_subtracts(cur_op)),
    .a_bit       (in_a),
    .b_bit       (in_b),
    .sum_bit     (sum_bit),
    .lt_signed   (lt_s),
    .lt_unsigned (lt_u)
  );

  assign cmp_bit = (cur_op == OP_SLT) ? lt_s : lt_u;

  always_comb begin
    unique case (cur_op)
      OP_AND:         res_bit = in_a & in_b;
      OP_OR:          res_bit = in_a | in_b;
      OP_XOR:         res_bit = in_a ^ in_b;
      OP_ADD, OP_SUB: res_bit = sum_bit;
      default:        res_bit = 1'b0;
    endcase
  end

  serial_alu_shsel #(.XLEN(XLEN)) u_sh (
    .opnd  (opa_q),
    .shamt (opb_q[CNT_W-1:0]),
    .idx   (cnt_q),
    .left  (op_q == OP_SLL),
    .arith (op_q == OP_SRA),
    .bit_o (sh_bit)
  );

  serial_alu_mulcol #(.MUL_W(MUL_W)) u_mul (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (mode_q != SL_EXEC),
    .en    (mode_q == SL_EXEC),
    .a_bit (opa_q[cnt_q]),
    .b_lo  (opb_q),
    .p_bit (mul_bit)
  );

  assign exec_bit = (op_q == OP_MUL) ? mul_bit : sh_bit;
  assign out_bit  = (mode_q == SL_EXEC) ? exec_bit : res_q[0];
  assign out_last = out_valid & (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= SL_IDLE;
      cnt_q  <= '0;
      op_q   <= OP_AND;
      pend_q <= 1'b0;
      res_q  <= '0;
      opa_q  <= '0;
      opb_q  <= '0;
    end else begin
      mode_q <= mode_d;
      if (step) cnt_q <= cnt_q + 1'b1;
      if (accept && at_idle) op_q <= alu_op_e'(in_op);
      if (at_end && mode_q == SL_RUN)   pend_q <= ~op_two_slot(op_q);
      if (at_end && mode_q == SL_DRAIN) pend_q <= 1'b0;
      if (accept) begin
        opa_q <= {in_a, opa_q[XLEN-1:1]};
        if (cnt_q < CNT_W'(MUL_W)) opb_q[cnt_q[MB_W-1:0]] <= in_b;
        if (op_compares(cur_op) && cnt_q == LAST) res_q <= {{(XLEN-1){1'b0}}, cmp_bit};
        else                                      res_q <= {res_bit, res_q[XLEN-1:1]};
      end else if (step && mode_q != SL_EXEC) begin
        res_q <= res_q >> 1;
      end
    end
  end

endmodule

// File: rtl/serial_alu_chk.sv
module serial_alu_chk
  import serial_alu_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_last,
  input logic [1:0]       mode,
  input logic [CNT_W-1:0] cnt,
  input logic [3:0]       op_q
);

  localparam logic [CNT_W-1:0] LAST = '1;

  AST_EXEC_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SL_EXEC) |-> (!in_ready && out_valid)); // R7

  AST_TWO_SLOT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SL_RUN && in_valid && in_ready && cnt == LAST && op_two_slot(alu_op_e'(op_q)))
      |=> (mode == SL_EXEC)); // R8

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SL_RUN && !in_valid) |=> $stable(cnt)); // R9

  AST_STALL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SL_RUN && !in_valid) |-> !out_valid); // R9

  AST_DRAIN_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SL_DRAIN) |-> (!in_ready && out_valid)); // R6

  AST_LAST_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> (cnt == '0)); // R10

  AST_LAST_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid); // R10

endmodule

bind serial_alu serial_alu_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_last  (out_last),
  .mode      (mode_q),
  .cnt       (cnt_q),
  .op_q      (op_q)
);

// File: tb/serial_alu_tb.sv
`timescale 1ns/1ps
module serial_alu_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [3:0] in_op = 4'd0;
  logic       in_a = 1'b0;
  logic       in_b = 1'b0;
  logic       out_valid;
  logic       out_bit;
  logic       out_last;

  int checks = 0;
  int fails  = 0;
  int waits  = 0;
  bit done   = 1'b0;

  logic [31:0] exp_q[$];
  int          tag_q[$];
  logic [31:0] word;
  int          idx = 0;

  always #5 clk = ~clk;

  serial_alu u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_bit(out_bit), .out_last(out_last)
  );

  function automatic logic [31:0] model(int op, logic [31:0] a, logic [31:0] b);
    case (op)
      0: return a & b;
      1: return a | b;
      2: return a ^ b;
      3: return a + b;
      4: return a - b;
      5: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      6: return (a < b) ? 32'd1 : 32'd0;
      7: return a << b[4:0];
      8: return a >> b[4:0];
      9: return $unsigned($signed(a) >>> b[4:0]);
      10: return a * (b & 32'h0000_FFFF);
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag(int op);
    if (op <= 2) return "R2";
    if (op <= 4) return "R3";
    if (op <= 6) return "R4";
    if (op <= 9) return "R7";
    if (op == 10) return "R8";
    return "R12";
  endfunction

  task automatic check(bit ok, string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Result monitor: compares each result word against the reference queue
  always @(negedge clk) begin
    if (rst_n && out_valid && !done) begin
      word[idx] = out_bit;
      if (out_last) begin
        check(idx == 31, "R10 last position", 32'(idx), 32'd31);
        if (exp_q.size() == 0) begin
          check(1'b0, "R5 unexpected result", word, 32'd0);
        end else begin
          automatic logic [31:0] e = exp_q.pop_front();
          automatic int t = tag_q.pop_front();
          check(word == e, tag(t), word, e);
        end
        idx = 0;
      end else begin
        idx++;
        if (idx > 31) begin
          check(1'b0, "R10 missing last", 32'(idx), 32'd31);
          idx = 0;
        end
      end
    end
  end

  // Drive one operation; stall_at>0 drops in_valid before that beat, scramble changes in_op after beat 0
  task automatic send_op(int op, logic [31:0] a, logic [31:0] b, int stall_at, int stall_len, bit scramble);
    exp_q.push_back(model(op, a, b));
    tag_q.push_back(op);
    for (int i = 0; i < 32; i++) begin
      if (i == stall_at && stall_len > 0) begin
        in_valid = 1'b0;
        for (int s = 0; s < stall_len; s++) begin
          @(negedge clk);
          check(!out_valid && in_ready, "R9 stall", {30'd0, out_valid, in_ready}, 32'd1);
          @(posedge clk); #1;
        end
      end
      in_valid = 1'b1;
      in_op = (scramble && i > 0) ? ~op[3:0] : op[3:0];
      in_a = a[i];
      in_b = b[i];
      @(negedge clk);
      while (!in_ready) begin
        waits++;
        @(negedge clk);
      end
      @(posedge clk); #1;
    end
  endtask

  task automatic go_idle(int n);
    in_valid = 1'b0;
    repeat (n) begin @(posedge clk); #1; end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1;
    check(!out_valid && !out_last && in_ready, "R11 in reset", {29'd0, out_valid, out_last, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && !out_last && in_ready, "R11 after reset", {29'd0, out_valid, out_last, in_ready}, 32'd1);
    @(posedge clk); #1;

    // One-slot ops back to back; a stall inside the second and a late opcode change in the third
    waits = 0;
    send_op(0, 32'hF0F0_A5A5, 32'hFF00_FF00, 0, 0, 1'b0);
    send_op(1, 32'h1234_5678, 32'h0F0F_0F0F, 10, 3, 1'b0);
    send_op(2, 32'hDEAD_BEEF, 32'hFFFF_0000, 0, 0, 1'b1);   // R1 opcode only from first beat
    send_op(3, 32'hFFFF_FFFF, 32'h0000_0001, 0, 0, 1'b0);
    send_op(3, 32'h7FFF_FFFF, 32'h0000_0001, 0, 0, 1'b0);
    send_op(4, 32'h0000_0000, 32'h0000_0001, 0, 0, 1'b0);
    send_op(4, 32'h8000_0000, 32'h1234_5678, 0, 0, 1'b0);
    check(waits == 0, "R5 back-to-back ready", 32'(waits), 32'd0);

    // Drain slot after the last one-slot op (R6)
    in_valid = 1'b0;
    begin
      automatic int nv = 0;
      automatic int badr = 0;
      for (int k = 0; k < 32; k++) begin
        @(negedge clk);
        if (out_valid) nv++;
        if (k > 0 && in_ready) badr++;
      end
      check(nv == 32, "R6 drain contiguous", 32'(nv), 32'd32);
      check(badr == 0, "R6 drain not ready", 32'(badr), 32'd0);
      @(negedge clk);
      check(!out_valid, "R6 drain ended", {31'd0, out_valid}, 32'd0);
    end
    @(posedge clk); #1;

    // Compares
    send_op(5, 32'hFFFF_FFFF, 32'h0000_0001, 0, 0, 1'b0);
    send_op(5, 32'h0000_0001, 32'hFFFF_FFFF, 0, 0, 1'b0);
    send_op(5, 32'h8000_0000, 32'h0000_0001, 0, 0, 1'b0);
    send_op(5, 32'h7FFF_FFFF, 32'h8000_0000, 0, 0, 1'b0);
    send_op(6, 32'h0000_0001, 32'hFFFF_FFFF, 0, 0, 1'b0);
    send_op(6, 32'h5555_5555, 32'h5555_5555, 5, 2, 1'b0);
    send_op(12, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 1'b0);
    go_idle(40);

    // Shift, then check the exec slot blocks input (R7)
    send_op(7, 32'h8123_4567, 32'hFFFF_FFE4, 0, 0, 1'b0);
    in_valid = 1'b0;
    begin
      automatic int bad = 0;
      for (int k = 0; k < 32; k++) begin
        @(negedge clk);
        if (in_ready || !out_valid) bad++;
      end
      check(bad == 0, "R7 exec slot blocks input", 32'(bad), 32'd0);
    end
    @(posedge clk); #1;
    send_op(8, 32'h8000_0001, 32'h0000_001F, 0, 0, 1'b0);
    send_op(9, 32'h8765_4321, 32'hABCD_0007, 0, 0, 1'b0);
    send_op(9, 32'h1765_4321, 32'h0000_0004, 0, 0, 1'b0);
    send_op(7, 32'hCAFE_F00D, 32'h0000_0020, 0, 0, 1'b0);
    send_op(8, 32'hCAFE_F00D, 32'h0000_0000, 0, 0, 1'b0);

    // Multiply, upper half of b ignored (R8)
    send_op(10, 32'h1234_5678, 32'hFFFF_ABCD, 0, 0, 1'b0);
    send_op(10, 32'hFFFF_FFFF, 32'h0000_FFFF, 0, 0, 1'b0);
    send_op(3, 32'h0000_0000, 32'h1234_5000, 0, 0, 1'b0);   // upper-immediate style add
    send_op(10, 32'h0000_0003, 32'h8000_0005, 7, 2, 1'b0);
    send_op(10, 32'h8000_0000, 32'h0000_0002, 0, 0, 1'b0);
    go_idle(80);

    check(exp_q.size() == 0, "R5 all results delivered", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule